// File: doc/BRIEF.md
# Intra 4x4 Luma Mode Decision Controller

This block chooses the prediction mode for each of the sixteen 4x4 luma blocks of a macroblock. For each block it receives the SATD of all nine 4x4 prediction modes, the modes and availability of the left and upper neighbours, and a lambda weight. It returns the winning mode, the winning cost (SATD plus lambda times the bits needed to signal the mode), and a flag that tells the upstream SATD engine whether every mode had to be evaluated for this block.

Four block positions in every macroblock are always searched over all nine modes. The other twelve consider only a short candidate list built from their neighbours. The block keeps the smallest SATD seen on the always-full blocks of the current macroblock. A partial-search block whose best candidate SATD is more than twice that value falls back to a search over all nine modes. Blocks are presented one per cycle, in macroblock order starting at index 0, and the decision appears one cycle later.

Top module: `i4_mode_decision`

## Requirements
- R1: Blocks with index 0, 2, 8 or 10 are searched over all nine modes (0..8), and `out_full` is 1 for them.
- R2: On any other block the candidates are DC (mode 2) plus the left and top neighbour modes when both neighbours are available, and only DC when either one is missing. Modes outside this list cannot win unless R5 applies.
- R3: The cost of a mode is its SATD plus lambda when the mode equals the most probable mode, or plus 4 times lambda when it does not. The most probable mode is the smaller of the left and top modes when both are available, and 2 otherwise.
- R4: The chosen mode has the smallest cost among the candidates. On equal cost the lower mode number wins. `out_cost` reports that cost.
- R5: The threshold is twice the smallest per-block minimum SATD over the always-full blocks already decided in the current macroblock. A partial-search block whose best candidate SATD is strictly above the threshold is searched over all nine modes, and `out_full` is 1.
- R6: A partial-search block whose best candidate SATD equals the threshold is not escalated, and `out_full` is 0.
- R7: Block index 0 starts a new macroblock and discards the previous minimum. While no always-full block of the current macroblock has been decided, including straight after reset, the threshold is the maximum value and no escalation happens.
- R8: `out_valid` pulses exactly one cycle after each `in_valid` cycle, and back-to-back blocks are accepted. `out_mode`, `out_cost` and `out_full` change only on those cycles.
- R9: During and after reset `out_valid`, `out_mode`, `out_cost` and `out_full` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A block's inputs are presented this cycle |
| blk_idx | input | 4 | 4x4 block index within the macroblock, 0..15 |
| left_avail | input | 1 | Left neighbour exists |
| top_avail | input | 1 | Upper neighbour exists |
| left_mode | input | 4 | Mode chosen for the left neighbour |
| top_mode | input | 4 | Mode chosen for the upper neighbour |
| lambda | input | LAMBDA_W (8) | Rate weight |
| satd_flat | input | 9*SATD_W (144) | SATD for mode m in bits [m*SATD_W +: SATD_W] |
| out_valid | output | 1 | Decision valid |
| out_mode | output | 4 | Chosen mode |
| out_cost | output | COST_W (17) | Cost of the chosen mode |
| out_full | output | 1 | All nine modes were evaluated for this block |

## Verification
The only internal state is the running minimum of the always-full SATD and its valid bit. A wrong minimum shows up at the ports as a change in `out_full`, and usually in `out_mode`, on the first partial-search block after the faulty update, one cycle after that block is presented. The bench therefore puts partial blocks right after full blocks, with the candidate SATD placed exactly at, just above, and far above twice the expected minimum. It also runs the first partial block of a new macroblock against a minimum left over from the previous one, so a missing clear is caught. Cost and mode errors show at once in `out_cost` and `out_mode` on the block that causes them.

// File: rtl/i4_md_pkg.sv
package i4_md_pkg;
  localparam int NMODES   = 9;
  localparam int MODE_W   = 4;
  localparam int DC_MODE  = 2;
  localparam int NBLK     = 16;
  localparam int IDX_W    = 4;
  typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/i4_cand_mask.sv
module i4_cand_mask
  import i4_md_pkg::*;
(
  input  logic              left_avail,
  input  logic              top_avail,
  input  mode_t             left_mode,
  input  mode_t             top_mode,
  output mode_t             mpm,
  output logic [NMODES-1:0] part_mask
);
  logic both;
  assign both = left_avail & top_avail;

  always_comb begin
    if (both) mpm = (left_mode < top_mode) ? left_mode : top_mode;
    else      mpm = mode_t'(DC_MODE);
  end

  for (genvar m = 0; m < NMODES; m++) begin : g_mask
    if (m == DC_MODE) begin : g_dc
      assign part_mask[m] = 1'b1;
    end else begin : g_nb
      assign part_mask[m] = both & ((left_mode == mode_t'(m)) | (top_mode == mode_t'(m)));
    end
  end
endmodule

// File: rtl/i4_min_reduce.sv
module i4_min_reduce #(
  parameter int N = 9,
  parameter int W = 16
) (
  input  logic [N*W-1:0] vals,
  input  logic [N-1:0]   mask,
  output logic [W-1:0]   min_val
);
  always_comb begin
    min_val = '1;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (vals[i*W +: W] < min_val)) min_val = vals[i*W +: W];
    end
  end
endmodule

// File: rtl/i4_argmin.sv
module i4_argmin #(
  parameter int N  = 9,
  parameter int W  = 17,
  parameter int IW = 4
) (
  input  logic [N*W-1:0] vals,
  input  logic [N-1:0]   mask,
  output logic [W-1:0]   min_val,
  output logic [IW-1:0]  min_idx
);
  logic found;
  always_comb begin
    min_val = '1;
    min_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || (vals[i*W +: W] < min_val))) begin
        min_val = vals[i*W +: W];
        min_idx = IW'(i);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i4_thresh_track.sv
module i4_thresh_track #(
  parameter int SATD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              mb_start,
  input  logic              full_pos,
  input  logic [SATD_W-1:0] blk_min,
  output logic [SATD_W:0]   thr
);
  logic [SATD_W-1:0] min_q, min_d;
  logic              have_q, have_d;
  logic              en;

  assign thr = (have_q && !mb_start) ? {min_q, 1'b0} : '1;

  always_comb begin
    en     = upd_en && (full_pos || mb_start);
    min_d  = min_q;
    have_d = have_q;
    if (full_pos) begin
      if (mb_start || !have_q || (blk_min < min_q)) min_d = blk_min;
      have_d = 1'b1;
    end else begin
      have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '0;
      have_q <= 1'b0;
    end else if (en) begin
      min_q  <= min_d;
      have_q <= have_d;
    end
  end
endmodule

// File: rtl/i4_mode_decision.sv
module i4_mode_decision
  import i4_md_pkg::*;
#(
  parameter int              SATD_W        = 16,
  parameter int              LAMBDA_W      = 8,
  parameter logic [NBLK-1:0] FULL_POS_MASK = 16'h0505,
  localparam int             RATE_W        = LAMBDA_W + 2,
  localparam int             COST_W        = ((SATD_W > RATE_W) ? SATD_W : RATE_W) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IDX_W-1:0]         blk_idx,
  input  logic                     left_avail,
  input  logic                     top_avail,
  input  logic [MODE_W-1:0]        left_mode,
  input  logic [MODE_W-1:0]        top_mode,
  input  logic [LAMBDA_W-1:0]      lambda,
  input  logic [NMODES*SATD_W-1:0] satd_flat,
  output logic                     out_valid,
  output logic [MODE_W-1:0]        out_mode,
  output logic [COST_W-1:0]        out_cost,
  output logic                     out_full
);
  mode_t              mpm;
  logic [NMODES-1:0]  part_mask, sel_mask;
  logic [SATD_W-1:0]  part_min, blk_min;
  logic [SATD_W:0]    thr;
  logic               full_pos, mb_start, escalate, use_all;
  logic [NMODES*COST_W-1:0] cost_flat;
  logic [COST_W-1:0]  best_cost;
  mode_t              best_mode;

  logic              valid_d, full_d;
  mode_t             mode_d;
  logic [COST_W-1:0] cost_d;

  assign full_pos = FULL_POS_MASK[blk_idx];
  assign mb_start = (blk_idx == '0);

  i4_cand_mask u_cand (
    .left_avail (left_avail),
    .top_avail  (top_avail),
    .left_mode  (left_mode),
    .top_mode   (top_mode),
    .mpm        (mpm),
    .part_mask  (part_mask)
  );

  i4_min_reduce #(.N(NMODES), .W(SATD_W)) u_part_min (
    .vals    (satd_flat),
    .mask    (part_mask),
    .min_val (part_min)
  );

  i4_min_reduce #(.N(NMODES), .W(SATD_W)) u_blk_min (
    .vals    (satd_flat),
    .mask    ({NMODES{1'b1}}),
    .min_val (blk_min)
  );

  i4_thresh_track #(.SATD_W(SATD_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (in_valid),
    .mb_start (mb_start),
    .full_pos (full_pos),
    .blk_min  (blk_min),
    .thr      (thr)
  );

  assign escalate = !full_pos && ({1'b0, part_min} > thr);
  assign use_all  = full_pos || escalate;
  assign sel_mask = use_all ? {NMODES{1'b1}} : part_mask;

  for (genvar m = 0; m < NMODES; m++) begin : g_cost
    logic [COST_W-1:0] rate;
    assign rate = (mpm == mode_t'(m)) ? COST_W'(lambda) : (COST_W'(lambda) << 2);
    assign cost_flat[m*COST_W +: COST_W] = COST_W'(satd_flat[m*SATD_W +: SATD_W]) + rate;
  end

  i4_argmin #(.N(NMODES), .W(COST_W), .IW(MODE_W)) u_pick (
    .vals    (cost_flat),
    .mask    (sel_mask),
    .min_val (best_cost),
    .min_idx (best_mode)
  );

  always_comb begin
    valid_d = in_valid;
    mode_d  = out_mode;
    cost_d  = out_cost;
    full_d  = out_full;
    if (in_valid) begin
      mode_d = best_mode;
      cost_d = best_cost;
      full_d = use_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mode <= '0;
      out_cost <= '0;
      out_full <= 1'b0;
    end else if (in_valid) begin
      out_mode <= mode_d;
      out_cost <= cost_d;
      out_full <= full_d;
    end
  end
endmodule

// File: rtl/i4_mode_decision_chk.sv
module i4_mode_decision_chk #(
  parameter int          LAMBDA_W      = 8,
  parameter int          COST_W        = 17,
  parameter logic [15:0] FULL_POS_MASK = 16'h0505
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3:0]          blk_idx,
  input logic                left_avail,
  input logic                top_avail,
  input logic [LAMBDA_W-1:0] lambda,
  input logic                out_valid,
  input logic [3:0]          out_mode,
  input logic [COST_W-1:0]   out_cost,
  input logic                out_full
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mode) && $stable(out_cost) && $stable(out_full)));
  p_full_position_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && FULL_POS_MASK[blk_idx]) |=> out_full);
  p_mode_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode < 4'd9));
  p_dc_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(left_avail && top_avail)) |=> (out_full || (out_mode == 4'd2)));
  p_cost_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_cost >= COST_W'($past(lambda))));
endmodule

bind i4_mode_decision i4_mode_decision_chk #(
  .LAMBDA_W      (LAMBDA_W),
  .COST_W        (COST_W),
  .FULL_POS_MASK (FULL_POS_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .blk_idx    (blk_idx),
  .left_avail (left_avail),
  .top_avail  (top_avail),
  .lambda     (lambda),
  .out_valid  (out_valid),
  .out_mode   (out_mode),
  .out_cost   (out_cost),
  .out_full   (out_full)
);

// File: tb/tb_i4_mode_decision.sv
module tb_i4_mode_decision;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int LW = 8;
  localparam int CW = 17;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [3:0]      blk_idx = '0;
  logic            left_avail = 1'b0, top_avail = 1'b0;
  logic [3:0]      left_mode = '0, top_mode = '0;
  logic [LW-1:0]   lambda = '0;
  logic [9*SW-1:0] satd_flat = '0;
  logic            out_valid, out_full;
  logic [3:0]      out_mode;
  logic [CW-1:0]   out_cost;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {int mode; int cost; bit full; string tag;} exp_t;
  exp_t q[$];

  int  m_min  = 0;
  bit  m_have = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i4_mode_decision dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blk_idx(blk_idx),
    .left_avail(left_avail), .top_avail(top_avail), .left_mode(left_mode),
    .top_mode(top_mode), .lambda(lambda), .satd_flat(satd_flat),
    .out_valid(out_valid), .out_mode(out_mode), .out_cost(out_cost),
    .out_full(out_full)
  );

  task automatic drive_blk(input int idx, input bit la, input bit ta,
                           input int lm, input int tm, input int lam,
                           input int s[9], input string tag);
    int mpm, thr, pmin, bmin, bc, bm;
    bit fullp, esc, both;
    bit mask[9];
    exp_t e;
    both  = la && ta;
    mpm   = both ? ((lm < tm) ? lm : tm) : 2;
    fullp = (idx == 0) || (idx == 2) || (idx == 8) || (idx == 10);
    thr   = (m_have && idx != 0) ? 2 * m_min : 32'h7fffffff;
    pmin  = 32'h7fffffff;
    bmin  = 32'h7fffffff;
    for (int m = 0; m < 9; m++) begin
      mask[m] = fullp || (m == 2) || (both && (m == lm || m == tm));
      if (mask[m] && s[m] < pmin) pmin = s[m];
      if (s[m] < bmin) bmin = s[m];
    end
    esc = !fullp && (pmin > thr);
    if (esc) for (int m = 0; m < 9; m++) mask[m] = 1'b1;
    bc = 32'h7fffffff; bm = 0;
    for (int m = 0; m < 9; m++) begin
      int c;
      c = s[m] + ((m == mpm) ? lam : 4 * lam);
      if (mask[m] && c < bc) begin bc = c; bm = m; end
    end
    if (fullp) begin
      if (idx == 0 || !m_have || bmin < m_min) m_min = bmin;
      m_have = 1'b1;
    end else if (idx == 0) begin
      m_have = 1'b0;
    end
    e.mode = bm; e.cost = bc; e.full = fullp || esc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_valid   = 1'b1;
    blk_idx    = 4'(idx);
    left_avail = la; top_avail = ta;
    left_mode  = 4'(lm); top_mode = 4'(tm);
    lambda     = LW'(lam);
    for (int m = 0; m < 9; m++) satd_flat[m*SW +: SW] = SW'(s[m]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_mode != 4'(e.mode) || out_cost != CW'(e.cost) || out_full != e.full) begin
          n_fail++;
          $display("FAIL %s: actual mode=%0d cost=%0d full=%0d expected mode=%0d cost=%0d full=%0d",
                   e.tag, out_mode, out_cost, out_full, e.mode, e.cost, e.full);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_full !== 1'b0 || out_mode !== 4'd0 || out_cost !== '0) begin
      n_fail++;
      $display("FAIL R9 reset: actual valid=%0d full=%0d mode=%0d cost=%0d expected all 0",
               out_valid, out_full, out_mode, out_cost);
    end
    rst_n = 1'b1;
    idle(2);

    // R7: straight after reset a huge partial SATD must not escalate
    drive_blk(1, 0, 0, 0, 0, 1, '{0,0,60000,0,0,0,0,0,0}, "R7 no threshold after reset");
    idle(2);

    // Macroblock A, back-to-back blocks (R8)
    drive_blk(0, 0, 0, 0, 0, 4, '{50,40,30,60,20,70,80,90,25}, "R1 R3 full block mpm bonus");
    drive_blk(1, 1, 1, 4, 1, 4, '{0,35,35,35,10,35,35,35,35}, "R2 R3 neighbour candidates");
    drive_blk(2, 0, 0, 0, 0, 0, '{100,100,100,10,100,10,100,100,100}, "R4 tie to lower mode");
    drive_blk(3, 0, 1, 0, 5, 2, '{0,0,15,0,0,0,0,0,0}, "R2 DC only missing left");
    drive_blk(4, 0, 0, 0, 0, 1, '{1,1,20,1,1,1,1,1,1}, "R6 equal threshold no escalation");
    drive_blk(5, 0, 0, 0, 0, 1, '{30,30,21,30,30,30,30,5,30}, "R5 escalation above threshold");
    idle(1);
    drive_blk(8, 0, 0, 0, 0, 3, '{9,50,50,50,50,50,50,50,50}, "R1 full block index 8");
    drive_blk(9, 0, 0, 0, 0, 1, '{0,30,19,30,30,30,30,30,30}, "R5 threshold follows new minimum");
    drive_blk(10, 1, 1, 6, 7, 2, '{40,40,40,40,40,40,33,31,40}, "R1 R3 full block index 10");
    drive_blk(11, 1, 1, 6, 3, 5, '{90,90,70,60,90,90,80,90,90}, "R5 escalation with neighbours");
    idle(2);

    // Macroblock B: index 0 must discard the old minimum (R7)
    drive_blk(0, 0, 0, 0, 0, 1, '{100,120,130,140,150,160,170,180,190}, "R7 new macroblock full");
    drive_blk(1, 0, 0, 0, 0, 1, '{0,0,150,0,0,0,0,0,0}, "R7 old minimum discarded");
    drive_blk(3, 1, 1, 8, 8, 10, '{0,0,250,0,0,0,0,0,0}, "R5 escalation in new macroblock");
    drive_blk(6, 1, 1, 1, 0, 255, '{0,0,0,0,0,0,0,0,0}, "R3 R4 rate decides on zero SATD");
    idle(4);

    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R8 missing outputs: actual %0d pending expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule